// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider Chain

This block holds the two integer dividers of a synthesizer loop. The feedback side counts a fast clock through a model of a dual-modulus prescaler, a swallow counter and a main counter. Software supplies one total ratio N and never sees the split. The block picks the prescaler size P from the selected path and derives the swallow count A = N mod P and the main count M = N div P. A divide-by-2 stage sits ahead of the chain on the two RF paths and is bypassed on the IF path. A power-of-two post-divider gives an IF output tick.

The reference side counts a reference clock by R. An optional halving stage ahead of it serves fast reference sources. The lowest legal R depends on the loop-gain code.

Each divider emits one single-cycle pulse per terminal count in its own clock domain. A new N, path, R, halving choice or post-divide code is taken only at that divider's next terminal count, so a period in progress always runs to completion. An out-of-range N or R is clamped to the nearest legal value and raises an error flag.

Top module: `pulse_swallow_divider`

## Requirements
- R1: On the IF path (path code 10 or 11), fb_pulse repeats every N fast clocks. The chain uses prescaler size P = 8 and the pulse-swallow split A = N mod P, M = N div P.
- R2: On an RF path (path code 00 with P = 32, path code 01 with P = 16), a divide-by-2 stage precedes the chain, so fb_pulse repeats every 2N fast clocks.
- R3: The path uses the low 18 bits of n_word for code 00, the low 17 bits for code 01 and the low 16 bits for the IF codes. Bits above the path's width have no effect on the period.
- R4: Each path has a minimum N: 992 for code 00, 240 for code 01 and 56 for IF. A lower N is divided as that minimum. n_err is high one cycle after the masked N falls below the minimum of the selected path, and low otherwise.
- R5: A change of n_word or path_sel takes effect only at the next fb_pulse. The feedback period in progress keeps its full length.
- R6: fb_pulse and ref_pulse are high for exactly one cycle of their own clock.
- R7: ref_pulse repeats every R reference clocks with ref_half low, and every 2R with ref_half high. A change of R or ref_half takes effect at the next ref_pulse.
- R8: The legal R range runs up to 8189. Its lower bound is 7, 8, 10 or 14 for gain code 00, 01, 10 or 11. An R outside the range is divided as the nearest bound, and r_err is high one cycle later.
- R9: While the IF path is active, post_pulse repeats every 1, 2, 4 or 8 fast clocks for post_sel 00, 01, 10 or 11, and a new code is taken at the next post_pulse. While an RF path is active, post_pulse stays low.
- R10: A synchronous active-high reset holds all outputs low. Each reset belongs to its own clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Fast (oscillator) clock |
| rst_vco | input | 1 | Synchronous reset, fast domain |
| clk_ref | input | 1 | Reference clock |
| rst_ref | input | 1 | Synchronous reset, reference domain |
| path_sel | input | 2 | 00 RF path 1, 01 RF path 2, 1x IF path |
| n_word | input | 18 | Total feedback ratio N |
| post_sel | input | 2 | IF post-divide code (1/2/4/8) |
| r_word | input | 13 | Reference ratio R |
| gain_sel | input | 2 | Loop-gain code, sets the R floor |
| ref_half | input | 1 | Halve the reference before the R counter |
| fb_pulse | output | 1 | Divided feedback pulse |
| post_pulse | output | 1 | Post-divided IF tick |
| n_err | output | 1 | N below the path minimum |
| ref_pulse | output | 1 | Divided reference pulse |
| r_err | output | 1 | R outside the legal range |

## Verification
The hardest case to reach is a change of N partway through a feedback period. The update has to land after the shadow capture and before the terminal count. The bench aligns to an fb_pulse, counts thirty clocks, rewrites N, and checks that the period in progress keeps the old length and the next period takes the new one. Switches between the RF and IF paths realign the divide-by-2 phase. Every table vector therefore discards one period before it measures.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  typedef enum logic [1:0] {PATH_RF1 = 2'b00, PATH_RF2 = 2'b01, PATH_IF = 2'b10} path_e;

  function automatic path_e decode_path(input logic [1:0] code);
    if (code[1]) return PATH_IF;
    if (code[0]) return PATH_RF2;
    return PATH_RF1;
  endfunction

  function automatic int r_floor(input logic [1:0] gain);
    case (gain)
      2'b00:   return 7;
      2'b01:   return 8;
      2'b10:   return 10;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/swallow_div.sv
`timescale 1ns/1ps
module swallow_div
  import psd_pkg::*;
#(
  parameter int N_W = 18,
  parameter int LP1 = 5,
  parameter int LP2 = 4,
  parameter int LPI = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     path_in,
  input  logic [N_W-1:0] n_in,
  output logic           fb_pulse,
  output logic           n_err,
  output logic           if_active
);
  localparam int PC_W = LP1 + 1;
  localparam int P1 = 1 << LP1;
  localparam int P2 = 1 << LP2;
  localparam int PI = 1 << LPI;
  localparam logic [N_W-1:0] MIN1  = N_W'(P1 * (P1 - 1));
  localparam logic [N_W-1:0] MIN2  = N_W'(P2 * (P2 - 1));
  localparam logic [N_W-1:0] MINI  = N_W'(PI * (PI - 1));
  localparam logic [N_W-1:0] MASK2 = {1'b0, {(N_W-1){1'b1}}};
  localparam logic [N_W-1:0] MASKI = {2'b00, {(N_W-2){1'b1}}};
  localparam logic [N_W-1:0] ONE   = N_W'(1);

  path_e          live_p, act_p;
  logic [N_W-1:0] n_mask, n_min, n_use, m_val, a_full;
  int             live_log, act_log;
  logic [PC_W-1:0] p_new, p_act, a_val;
  logic [PC_W-1:0] pre_cnt, a_left;
  logic [N_W-1:0]  m_cnt;
  logic            pre2, adv;

  assign live_p = decode_path(path_in);

  always_comb begin
    case (live_p)
      PATH_RF1: begin n_mask = n_in;         n_min = MIN1; live_log = LP1; end
      PATH_RF2: begin n_mask = n_in & MASK2; n_min = MIN2; live_log = LP2; end
      default:  begin n_mask = n_in & MASKI; n_min = MINI; live_log = LPI; end
    endcase
    case (act_p)
      PATH_RF1: act_log = LP1;
      PATH_RF2: act_log = LP2;
      default:  act_log = LPI;
    endcase
    n_use  = (n_mask < n_min) ? n_min : n_mask;
    a_full = n_use & ((ONE << live_log) - ONE);
    a_val  = a_full[PC_W-1:0];
    m_val  = n_use >> live_log;
    p_new  = PC_W'(1) << live_log;
    p_act  = PC_W'(1) << act_log;
  end

  assign adv       = (act_p == PATH_IF) | pre2;
  assign if_active = (act_p == PATH_IF);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_p    <= live_p;
      pre_cnt  <= '0;
      a_left   <= '0;
      m_cnt    <= '0;
      pre2     <= 1'b0;
      fb_pulse <= 1'b0;
      n_err    <= 1'b0;
    end else begin
      fb_pulse <= 1'b0;
      n_err    <= (n_mask < n_min);
      pre2     <= (act_p == PATH_IF) ? 1'b0 : ~pre2;
      if (adv) begin
        if (pre_cnt != '0) begin
          pre_cnt <= pre_cnt - 1'b1;
        end else if (m_cnt != '0) begin
          m_cnt <= m_cnt - 1'b1;
          if (a_left != '0) begin
            pre_cnt <= p_act;
            a_left  <= a_left - 1'b1;
          end else begin
            pre_cnt <= p_act - 1'b1;
          end
        end else begin
          fb_pulse <= 1'b1;
          act_p    <= live_p;
          m_cnt    <= m_val - 1'b1;
          if (a_val != '0) begin
            pre_cnt <= p_new;
            a_left  <= a_val - 1'b1;
          end else begin
            pre_cnt <= p_new - 1'b1;
            a_left  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/post_div.sv
`timescale 1ns/1ps
module post_div #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  input  logic              enable,
  output logic              post_pulse
);
  localparam int CNT_W = (1 << CODE_W) - 1;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   reload;

  assign reload = ((CNT_W+1)'(1) << code) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      post_pulse <= 1'b0;
    end else if (cnt == '0) begin
      cnt        <= reload[CNT_W-1:0];
      post_pulse <= enable;
    end else begin
      cnt        <= cnt - 1'b1;
      post_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/ref_div.sv
`timescale 1ns/1ps
module ref_div
  import psd_pkg::*;
#(
  parameter int R_W   = 13,
  parameter int R_MAX = 8189
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [R_W-1:0] r_in,
  input  logic [1:0]     gain,
  input  logic           half,
  output logic           ref_pulse,
  output logic           r_err
);
  logic [R_W-1:0] r_lo, r_use, r_cnt;
  logic           act_half, hph, adv, too_low, too_high;

  always_comb begin
    r_lo     = R_W'(r_floor(gain));
    too_low  = (r_in < r_lo);
    too_high = (r_in > R_W'(R_MAX));
    r_use    = too_low ? r_lo : (too_high ? R_W'(R_MAX) : r_in);
  end

  assign adv = ~act_half | hph;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_cnt     <= '0;
      act_half  <= half;
      hph       <= 1'b0;
      ref_pulse <= 1'b0;
      r_err     <= 1'b0;
    end else begin
      ref_pulse <= 1'b0;
      r_err     <= too_low | too_high;
      hph       <= act_half ? ~hph : 1'b0;
      if (adv) begin
        if (r_cnt != '0) begin
          r_cnt <= r_cnt - 1'b1;
        end else begin
          ref_pulse <= 1'b1;
          r_cnt     <= r_use - 1'b1;
          act_half  <= half;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_swallow_divider.sv
`timescale 1ns/1ps
module pulse_swallow_divider #(
  parameter int N_W   = 18,
  parameter int R_W   = 13,
  parameter int LP1   = 5,
  parameter int LP2   = 4,
  parameter int LPI   = 3,
  parameter int R_MAX = 8189
) (
  input  logic           clk_vco,
  input  logic           rst_vco,
  input  logic           clk_ref,
  input  logic           rst_ref,
  input  logic [1:0]     path_sel,
  input  logic [N_W-1:0] n_word,
  input  logic [1:0]     post_sel,
  input  logic [R_W-1:0] r_word,
  input  logic [1:0]     gain_sel,
  input  logic           ref_half,
  output logic           fb_pulse,
  output logic           post_pulse,
  output logic           n_err,
  output logic           ref_pulse,
  output logic           r_err
);
  logic if_active;

  swallow_div #(.N_W(N_W), .LP1(LP1), .LP2(LP2), .LPI(LPI)) u_fb (
    .clk(clk_vco), .rst(rst_vco), .path_in(path_sel), .n_in(n_word),
    .fb_pulse(fb_pulse), .n_err(n_err), .if_active(if_active)
  );

  post_div #(.CODE_W(2)) u_post (
    .clk(clk_vco), .rst(rst_vco), .code(post_sel), .enable(if_active),
    .post_pulse(post_pulse)
  );

  ref_div #(.R_W(R_W), .R_MAX(R_MAX)) u_ref (
    .clk(clk_ref), .rst(rst_ref), .r_in(r_word), .gain(gain_sel), .half(ref_half),
    .ref_pulse(ref_pulse), .r_err(r_err)
  );
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker #(
  parameter int N_W   = 18,
  parameter int R_W   = 13,
  parameter int LPI   = 3,
  parameter int R_MAX = 8189
) (
  input logic           clk_vco,
  input logic           rst_vco,
  input logic           clk_ref,
  input logic           rst_ref,
  input logic [N_W-1:0] n_word,
  input logic [R_W-1:0] r_word,
  input logic           fb_pulse,
  input logic           ref_pulse,
  input logic           n_err,
  input logic           r_err
);
  localparam int N_FLOOR = (1 << LPI) * ((1 << LPI) - 1);
  localparam int R_FLOOR = 7;

  logic [15:0] fb_gap, ref_gap;
  logic        fb_seen, ref_seen;

  always_ff @(posedge clk_vco) begin
    if (rst_vco) begin
      fb_gap <= '0; fb_seen <= 1'b0;
    end else if (fb_pulse) begin
      fb_gap <= '0; fb_seen <= 1'b1;
    end else if (fb_gap != 16'hFFFF) begin
      fb_gap <= fb_gap + 1'b1;
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst_ref) begin
      ref_gap <= '0; ref_seen <= 1'b0;
    end else if (ref_pulse) begin
      ref_gap <= '0; ref_seen <= 1'b1;
    end else if (ref_gap != 16'hFFFF) begin
      ref_gap <= ref_gap + 1'b1;
    end
  end

  AST_FB_MIN_GAP: assert property (@(posedge clk_vco) disable iff (rst_vco)
    (fb_pulse && fb_seen) |-> (fb_gap >= 16'(N_FLOOR - 1))); // R6
  AST_REF_MIN_GAP: assert property (@(posedge clk_ref) disable iff (rst_ref)
    (ref_pulse && ref_seen) |-> (ref_gap >= 16'(R_FLOOR - 1))); // R8
  AST_N_TINY_FLAG: assert property (@(posedge clk_vco) disable iff (rst_vco)
    (!$past(rst_vco) && ($past(n_word) < N_W'(N_FLOOR))) |-> n_err); // R4
  AST_R_LOW_FLAG: assert property (@(posedge clk_ref) disable iff (rst_ref)
    (!$past(rst_ref) && ($past(r_word) < R_W'(R_FLOOR))) |-> r_err); // R8
  AST_R_HIGH_FLAG: assert property (@(posedge clk_ref) disable iff (rst_ref)
    (!$past(rst_ref) && ($past(r_word) > R_W'(R_MAX))) |-> r_err); // R8
endmodule

bind pulse_swallow_divider psd_checker #(.N_W(N_W), .R_W(R_W), .LPI(LPI), .R_MAX(R_MAX)) u_chk (
  .clk_vco(clk_vco), .rst_vco(rst_vco), .clk_ref(clk_ref), .rst_ref(rst_ref),
  .n_word(n_word), .r_word(r_word), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
  .n_err(n_err), .r_err(r_err)
);

// File: tb/pulse_swallow_divider_test.sv
`timescale 1ns/1ps
module pulse_swallow_divider_test;
  logic        clk = 1'b0;
  logic        rst_vco, rst_ref;
  logic [1:0]  path_sel, post_sel, gain_sel;
  logic [17:0] n_word;
  logic [12:0] r_word;
  logic        ref_half;
  logic        fb_pulse, post_pulse, n_err, ref_pulse, r_err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pulse_swallow_divider uut (
    .clk_vco(clk), .rst_vco(rst_vco), .clk_ref(clk), .rst_ref(rst_ref),
    .path_sel(path_sel), .n_word(n_word), .post_sel(post_sel), .r_word(r_word),
    .gain_sel(gain_sel), .ref_half(ref_half), .fb_pulse(fb_pulse),
    .post_pulse(post_pulse), .n_err(n_err), .ref_pulse(ref_pulse), .r_err(r_err)
  );

  // feedback vectors: path, N, expected period, expected n_err
  localparam int NV = 14;
  localparam int V_PATH[NV] = '{0, 0, 0, 1, 1, 2, 2, 2, 2, 0, 1, 2, 3, 1};
  localparam int V_N[NV]    = '{992, 1023, 1000, 240, 255, 56, 63, 100, 500,
                                500, 100, 10, 65636, 131372};
  localparam int V_PER[NV]  = '{1984, 2046, 2000, 480, 510, 56, 63, 100, 500,
                                1984, 480, 56, 100, 600};
  localparam int V_ERR[NV]  = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0};

  function automatic logic sigv(input int sel);
    case (sel)
      0:       return fb_pulse;
      1:       return post_pulse;
      default: return ref_pulse;
    endcase
  endfunction

  task automatic period(input int sel, output int c);
    int guard = 0;
    while (!sigv(sel) && guard < 20000) begin @(negedge clk); guard++; end
    c = 0;
    do begin @(negedge clk); c++; end while (!sigv(sel) && c < 20000);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(8ns * 190000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c, cnt;
    path_sel = 2'b10; n_word = 18'd56; post_sel = 2'b00;
    r_word = 13'd7; gain_sel = 2'b00; ref_half = 1'b0;
    rst_vco = 1'b1; rst_ref = 1'b1;
    repeat (3) @(negedge clk);
    // R10: outputs held low in reset
    check("R10 fb_pulse", fb_pulse, 0);
    check("R10 post_pulse", post_pulse, 0);
    check("R10 n_err", n_err, 0);
    check("R10 ref_pulse", ref_pulse, 0);
    check("R10 r_err", r_err, 0);
    rst_vco = 1'b0; rst_ref = 1'b0;

    // R1 R2 R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      path_sel = 2'(V_PATH[i]);
      n_word   = 18'(V_N[i]);
      period(0, c);
      period(0, c);
      check($sformatf("R1/R2/R3 vec%0d period", i), c, V_PER[i]);
      check($sformatf("R4 vec%0d n_err", i), n_err, V_ERR[i]);
    end

    // R6: fb_pulse lasts one cycle
    @(negedge clk);
    check("R6 fb_pulse width", fb_pulse, 0);

    // R5: mid-period update of N is deferred
    path_sel = 2'b10; n_word = 18'd100;
    period(0, c); period(0, c);
    repeat (30) @(negedge clk);
    n_word = 18'd60;
    c = 30;
    do begin @(negedge clk); c++; end while (!fb_pulse && c < 20000);
    check("R5 period in progress", c, 100);
    period(0, c);
    check("R5 next period", c, 60);

    // R9: post divider codes on IF path
    for (int k = 0; k < 4; k++) begin
      post_sel = 2'(k);
      period(1, c); period(1, c);
      check($sformatf("R9 post code %0d", k), c, 1 << k);
    end
    // R9: silent while RF path active
    path_sel = 2'b00; n_word = 18'd992;
    period(0, c);
    cnt = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); cnt += int'(post_pulse); end
    check("R9 post silent on RF", cnt, 0);

    // R7 R8: reference divider
    r_word = 13'd7; gain_sel = 2'b00; ref_half = 1'b0;
    period(2, c); period(2, c);
    check("R7 R=7 period", c, 7);
    check("R8 R=7 r_err", r_err, 0);
    @(negedge clk);
    check("R6 ref_pulse width", ref_pulse, 0);
    r_word = 13'd20; ref_half = 1'b1;
    period(2, c); period(2, c);
    check("R7 halved period", c, 40);
    r_word = 13'd5; ref_half = 1'b0;
    period(2, c); period(2, c);
    check("R8 low clamp period", c, 7);
    check("R8 low clamp r_err", r_err, 1);
    r_word = 13'd9; gain_sel = 2'b11;
    period(2, c); period(2, c);
    check("R8 gain 11 floor period", c, 14);
    check("R8 gain 11 r_err", r_err, 1);
    r_word = 13'd9; gain_sel = 2'b01;
    period(2, c); period(2, c);
    check("R8 gain 01 period", c, 9);
    check("R8 gain 01 r_err", r_err, 0);
    r_word = 13'd8191; gain_sel = 2'b00;
    period(2, c); period(2, c);
    check("R8 high clamp period", c, 8189);
    check("R8 high clamp r_err", r_err, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule